// File: doc/BRIEF.md
# Interrupt Pending and Mask Controller

This block gathers interrupt requests from up to sixteen sources and keeps, for each one, a pending flag that a rising edge on the source's request line raises. An enable mask and a global enable decide which pending sources may interrupt the processor. Among those, the lowest-numbered source is offered to a simple sequencer as a request with a vector index. When the sequencer accepts the request it acknowledges with that index, and the matching pending flag drops.

Software sees the pending and enable registers through a small register port. Each write carries one of three operations: replace, bitwise AND, or bitwise OR. The new value is formed in hardware against the current register contents within a single cycle. Software can therefore clear or raise individual pending flags without losing a hardware edge that lands in the same moment. A pulse that marks a restore of processor status and mask holds off any new request until the sequencer reports that the next instruction has finished.

Two of the sources are shared overrun lines. Each one is fed by a pair of capture/compare channels. A secondary overrun register records which channel overran, and software clears its bits by writing ones.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A rising edge on `src_req[i]` for an ordinary source sets pending bit i one clock later. A level held high sets nothing further. A level already high while reset is active does not count as an edge.
- R2: Pending bits are set whether or not the matching `mask` bit is set. The mask only decides whether a pending source can drive `irq_req`.
- R3: While `irq_req` is high, an `ack` pulse clears only the pending bit numbered `ack_vec`, one clock later. While `irq_req` is low, `ack` has no effect.
- R4: A bus write (`bus_sel` and `bus_wr` high) targets an address. Address 0 is the pending register and address 1 is the enable mask. `bus_op` selects the operation: 0 replaces the register with `bus_wdata`, 1 ANDs it with `bus_wdata`, 2 ORs `bus_wdata` into it, and 3 leaves it unchanged. The result is visible one clock later. `bus_rdata` shows the register at `bus_addr` combinationally.
- R5: When a hardware set of a pending bit falls in the same cycle as a software clear or an acknowledge of that bit, the bit ends up set. An AND operation never drops an edge that arrives in the same cycle on another bit.
- R6: When several pending sources are enabled, `irq_vec` gives the lowest-numbered one.
- R7: `irq_req` is high only while `glb_en` is high. `glb_en` does not change any pending bit.
- R8: A `ctx_restore` pulse forces `irq_req` low from the next cycle until the clock after the next `instr_done` pulse, and acknowledges are ignored during that time.
- R9: Overrun channels 0 and 1 feed source 12, and channels 2 and 3 feed source 13. An `ovr_evt` pulse sets its bit in the secondary register, which is read at address 2 in bits 3:0. The event also sets the shared pending bit, but only if that source's mask bit is set. `src_req` on sources 12 and 13 is ignored.
- R10: Any write to address 2 clears each secondary bit whose `bus_wdata` bit is 1. A new event on the same bit in the same cycle wins over the clear.
- R11: After reset, the pending, mask and secondary registers are zero and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 16 | Request lines, rising-edge active |
| ovr_evt | input | 4 | Overrun event pulses from four channels |
| glb_en | input | 1 | Global interrupt enable |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 pending, 1 mask, 2 overrun |
| bus_op | input | 2 | Write operation: 0 replace, 1 AND, 2 OR, 3 none |
| bus_wdata | input | 16 | Write data or operand |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| ctx_restore | input | 1 | Pulse marking a status/mask restore |
| instr_done | input | 1 | Instruction boundary strobe |
| ack | input | 1 | Sequencer acknowledge |
| ack_vec | input | 4 | Index being acknowledged |
| irq_req | output | 1 | Interrupt request to sequencer |
| irq_vec | output | 4 | Index of the winning source |

## Verification
The risky overlap is a hardware edge on a pending bit landing in the same cycle as a software AND that clears it, or as an acknowledge of that bit. The bench drives the edge and the bus operation (or the `ack`) on the same negative clock edge. It then reads the pending register back one cycle later and expects the bit to be set. It also checks that an AND aimed at one bit keeps an edge arriving on a neighbouring bit. The same approach covers a secondary overrun event meeting a write-one clear.

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int NSRC  = 16,
  parameter int VW    = $clog2(NSRC),
  parameter int OVR_A = 12,
  parameter int OVR_B = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [3:0]      ovr_evt,
  input  logic            glb_en,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [1:0]      bus_op,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  input  logic            ctx_restore,
  input  logic            instr_done,
  input  logic            ack,
  input  logic [VW-1:0]   ack_vec,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec
);
  localparam logic [NSRC-1:0] OVR_BITS = (NSRC'(1) << OVR_A) | (NSRC'(1) << OVR_B);
  localparam logic [1:0] OP_WR = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2;

  logic [NSRC-1:0] src_q, pend_q, mask_q;
  logic [3:0]      ovr_q;
  logic            inh_q;

  function automatic logic [NSRC-1:0] apply_op(input logic [NSRC-1:0] cur,
                                               input logic [1:0] op,
                                               input logic [NSRC-1:0] d);
    case (op)
      OP_WR:   return d;
      OP_AND:  return cur & d;
      OP_OR:   return cur | d;
      default: return cur;
    endcase
  endfunction

  wire bus_w    = bus_sel & bus_wr;
  wire wr_pend  = bus_w & (bus_addr == 2'd0);
  wire wr_mask  = bus_w & (bus_addr == 2'd1);
  wire wr_ovr   = bus_w & (bus_addr == 2'd2);

  wire [NSRC-1:0] rise   = src_req & ~src_q & ~OVR_BITS;
  wire            hit_a  = (|ovr_evt[1:0]) & mask_q[OVR_A];
  wire            hit_b  = (|ovr_evt[3:2]) & mask_q[OVR_B];
  wire [NSRC-1:0] hw_set = rise | (NSRC'(hit_a) << OVR_A) | (NSRC'(hit_b) << OVR_B);

  wire [NSRC-1:0] active  = pend_q & mask_q;
  wire [NSRC-1:0] ack_clr = (ack && irq_req) ? (NSRC'(1) << ack_vec) : '0;
  wire [NSRC-1:0] pend_sw = wr_pend ? apply_op(pend_q, bus_op, bus_wdata) : pend_q;
  wire [NSRC-1:0] mask_nx = wr_mask ? apply_op(mask_q, bus_op, bus_wdata) : mask_q;
  wire [3:0]      ovr_clr = wr_ovr ? bus_wdata[3:0] : 4'd0;

  assign irq_req = glb_en & ~inh_q & (|active);

  always_comb begin
    irq_vec = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (active[i]) irq_vec = VW'(i);
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = pend_q;
      2'd1:    bus_rdata = mask_q;
      2'd2:    bus_rdata = NSRC'(ovr_q);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= src_req;
      pend_q <= '0;
      mask_q <= '0;
      ovr_q  <= '0;
      inh_q  <= 1'b0;
    end else begin
      src_q  <= src_req;
      pend_q <= (pend_sw & ~ack_clr) | hw_set;
      mask_q <= mask_nx;
      ovr_q  <= (ovr_q & ~ovr_clr) | ovr_evt;
      if (ctx_restore)     inh_q <= 1'b1;
      else if (instr_done) inh_q <= 1'b0;
    end
  end
endmodule

module irq_pend_ctrl_chk #(
  parameter int NSRC  = 16,
  parameter int VW    = 4,
  parameter int OVR_A = 12,
  parameter int OVR_B = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req,
  input logic [3:0]      ovr_evt,
  input logic            glb_en,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [1:0]      bus_op,
  input logic [NSRC-1:0] bus_wdata,
  input logic            ctx_restore,
  input logic            ack,
  input logic [VW-1:0]   ack_vec,
  input logic            irq_req,
  input logic [VW-1:0]   irq_vec,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q
);
  localparam logic [NSRC-1:0] OVR_BITS = (NSRC'(1) << OVR_A) | (NSRC'(1) << OVR_B);
  logic [NSRC-1:0] prev_req;
  always_ff @(posedge clk) prev_req <= src_req;
  wire [NSRC-1:0] edges = src_req & ~prev_req & ~OVR_BITS;
  wire            or_pend = bus_sel && bus_wr && bus_addr == 2'd0 && bus_op == 2'd2;

  AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|edges) |=> ((pend_q & $past(edges)) == $past(edges))); // R1
  AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (glb_en && pend_q[irq_vec] && mask_q[irq_vec])); // R7
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend_q & mask_q & ((NSRC'(1) << irq_vec) - NSRC'(1))) == '0)); // R6
  AST_RESTORE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_restore |=> !irq_req); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !src_req[ack_vec] && ovr_evt == 4'd0) |=> !pend_q[$past(ack_vec)]); // R3
  AST_OR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (or_pend && !(ack && irq_req)) |=> ((pend_q & $past(bus_wdata)) == $past(bus_wdata))); // R4
  AST_OVR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ovr_evt[1:0]) && mask_q[OVR_A]) |=> pend_q[OVR_A]); // R9
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NSRC(NSRC), .VW(VW), .OVR_A(OVR_A), .OVR_B(OVR_B)) u_chk (.*);

// File: tb/irq_pend_ctrl_bench.sv
`timescale 1ns/1ps
module irq_pend_ctrl_bench;
  logic        clk = 0, rst_n = 0;
  logic [15:0] src_req = 0, bus_wdata = 0, bus_rdata;
  logic [3:0]  ovr_evt = 0, ack_vec = 0, irq_vec;
  logic        glb_en = 0, bus_sel = 0, bus_wr = 0, ctx_restore = 0, instr_done = 0, ack = 0, irq_req;
  logic [1:0]  bus_addr = 0, bus_op = 0;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_pend_ctrl u_irq_pend_ctrl (.*);

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] op, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_op = op; bus_wdata = d;
    step();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic do_ack(input logic [3:0] v);
    ack = 1; ack_vec = v; step(); ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; src_req = 0; ovr_evt = 0; glb_en = 0; bus_sel = 0; bus_wr = 0;
    ctx_restore = 0; instr_done = 0; ack = 0;
    repeat (3) step();
    rst_n = 1; step();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rst_n = 0; src_req = 16'h0020; repeat (3) step();
    rst_n = 1; step();
    rd(0, d); chk("R11 pend after reset", d, 0);
    rd(1, d); chk("R11 mask after reset", d, 0);
    rd(2, d); chk("R11 ovr after reset", d, 0);
    chk("R11 irq_req after reset", irq_req, 0);
    step(); rd(0, d); chk("R1 level held through reset is no edge", d, 0);
    src_req = 0;
  endtask

  task automatic t_edge();
    logic [15:0] d;
    do_reset();
    src_req[3] = 1; step();
    rd(0, d); chk("R1 R2 edge sets pend while masked", d, 16'h0008);
    chk("R2 masked pend gives no irq", irq_req, 0);
    wr(0, 1, 16'hFFF7); step();
    rd(0, d); chk("R1 held level sets nothing further", d, 0);
    src_req[3] = 0; step(); src_req[3] = 1; step();
    rd(0, d); chk("R1 new edge sets again", d, 16'h0008);
  endtask

  task automatic t_prio();
    logic [15:0] d;
    do_reset();
    glb_en = 1;
    wr(1, 0, 16'hFFFF);
    wr(0, 2, 16'h0088);
    chk("R6 irq_req with two pending", irq_req, 1);
    chk("R6 lowest index wins", irq_vec, 3);
    glb_en = 0; step();
    chk("R7 global enable off drops irq", irq_req, 0);
    rd(0, d); chk("R7 pend kept with global enable off", d, 16'h0088);
    glb_en = 1;
    wr(1, 1, 16'hFFF7);
    chk("R2 R4 mask AND removes bit3 from choice", irq_vec, 7);
    do_ack(7);
    rd(0, d); chk("R3 ack clears only vec 7", d, 16'h0008);
    chk("R2 masked pending gives no irq", irq_req, 0);
    do_ack(3);
    rd(0, d); chk("R3 ack ignored while irq_req low", d, 16'h0008);
  endtask

  task automatic t_swops();
    logic [15:0] d;
    do_reset();
    wr(0, 0, 16'hA5A5); rd(0, d); chk("R4 replace pend", d, 16'hA5A5);
    wr(0, 1, 16'h0F0F); rd(0, d); chk("R4 AND pend", d, 16'h0505);
    wr(0, 2, 16'h3000); rd(0, d); chk("R4 OR pend", d, 16'h3505);
    wr(0, 3, 16'h0000); rd(0, d); chk("R4 op 3 leaves pend", d, 16'h3505);
    wr(1, 0, 16'h1234); rd(1, d); chk("R4 replace mask", d, 16'h1234);
    wr(1, 2, 16'h0001); rd(1, d); chk("R4 OR mask", d, 16'h1235);
  endtask

  task automatic t_race();
    logic [15:0] d;
    do_reset();
    wr(0, 0, 16'h0200);
    src_req[9] = 1; wr(0, 1, 16'h0000);
    rd(0, d); chk("R5 edge beats AND clear same bit", d, 16'h0200);
    src_req[10] = 1; wr(0, 1, 16'hFDFF);
    rd(0, d); chk("R5 AND keeps concurrent edge on other bit", d, 16'h0400);
    src_req[10] = 0; glb_en = 1;
    wr(1, 0, 16'hFFFF);
    chk("R6 vec before ack race", irq_vec, 10);
    src_req[10] = 1; do_ack(10);
    rd(0, d); chk("R5 edge beats ack clear", d, 16'h0400);
  endtask

  task automatic t_inhibit();
    logic [15:0] d;
    do_reset();
    glb_en = 1;
    wr(1, 0, 16'hFFFF);
    wr(0, 2, 16'h0002);
    chk("R8 irq before restore", irq_req, 1);
    ctx_restore = 1; step(); ctx_restore = 0;
    chk("R8 irq held off after restore", irq_req, 0);
    step(); step();
    chk("R8 still held off before boundary", irq_req, 0);
    do_ack(1);
    rd(0, d); chk("R8 R3 ack ignored during hold-off", d, 16'h0002);
    instr_done = 1; step(); instr_done = 0;
    chk("R8 irq returns after boundary", irq_req, 1);
    chk("R8 vec after boundary", irq_vec, 1);
  endtask

  task automatic t_ovr();
    logic [15:0] d;
    do_reset();
    wr(1, 0, 16'h1000);
    ovr_evt = 4'b0010; step(); ovr_evt = 0;
    rd(2, d); chk("R9 secondary records channel 1", d, 16'h0002);
    rd(0, d); chk("R9 enabled overrun sets source 12", d, 16'h1000);
    ovr_evt = 4'b0100; step(); ovr_evt = 0;
    rd(2, d); chk("R9 secondary records channel 2", d, 16'h0006);
    rd(0, d); chk("R9 masked overrun leaves source 13 clear", d, 16'h1000);
    src_req[13] = 1; step();
    rd(0, d); chk("R9 src_req on overrun source ignored", d, 16'h1000);
    wr(2, 0, 16'h0002);
    rd(2, d); chk("R10 write one clears secondary bit", d, 16'h0004);
    ovr_evt = 4'b0100; wr(2, 1, 16'h0004); ovr_evt = 0;
    rd(2, d); chk("R10 event beats clear", d, 16'h0004);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_edge();
    t_prio();
    t_swops();
    t_race();
    t_inhibit();
    t_ovr();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule